// File: doc/BRIEF.md
# SDRAM command decoder and bank tracker

This block watches the control side of a single-data-rate SDRAM command bus. It captures clock enable, chip select, the three strobes, the bank address and the all-banks address bit on each rising edge. From these it works out which command was issued and keeps a record of which banks hold an open row. It also counts out the minimum spacing each command needs. Any command that breaks the protocol in the current state raises an error pulse. A bus monitor or controller self-check places it beside the memory interface.

Clock enable acts one edge late. A command counts only if clock enable was high at the edge before it. While clock enable is low, the per-bank and mode-settle counters hold their values. A refresh issued on the edge where clock enable drops puts the device into self-refresh. Any other drop puts it into power-down. Either state lasts until clock enable is sampled high again.

Top module: `sdr_cmd_monitor`

## Requirements
- R1: With chip select low on an enabled edge, the strobe levels (row, column, write; 0 = asserted) decode as: 011 activate (code 1), 101 read (2), 100 write (3), 010 precharge (4, or 5 for all banks when `addr_ap` is 1), 001 refresh (6), 000 mode load (7), 110 burst stop (8), 111 no-op. For every command other than no-op, `cmd_valid` is 1 and `cmd_code` holds the code in the cycle after the edge. No-op, deselect or a disabled edge give `cmd_valid` 0 and code 0. `proto_err` is only ever 1 together with `cmd_valid`.
- R2: An edge is enabled only if `cke` was 1 at the previous edge. A command on any other edge is not decoded and changes no bank state. The first edge after reset is never enabled.
- R3: A legal activate opens the selected bank. An activate to a bank that is already open raises `proto_err`.
- R4: A read or write raises `proto_err` if the bank is idle or fewer than TRCD enabled edges have passed since its activate.
- R5: A single-bank precharge closes the bank. It raises `proto_err` if the bank is open and fewer than TRAS enabled edges have passed since its activate. A precharge to an idle bank is legal.
- R6: Precharge-all closes every bank. If any open bank is younger than TRAS, it raises `proto_err` and closes none.
- R7: A mode load raises `proto_err` if any bank is open. After a legal mode load, any command other than no-op within TMRD enabled edges raises `proto_err`.
- R8: A refresh raises `proto_err` while any bank is open.
- R9: A legal refresh on an enabled edge where `cke` is 0 sets `self_refresh`. Any other enabled edge with `cke` 0 sets `power_down`. Both clear at the first edge where `cke` is 1, and they are never 1 together.
- R10: The TRCD, TRAS and TMRD counts advance only on enabled edges.
- R11: After reset all banks are idle, and `cmd_valid`, `proto_err`, `self_refresh` and `power_down` are 0. A command that raises `proto_err` leaves every bank's open state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BA_W | Bank address |
| addr_ap | input | 1 | Address bit that selects all banks on precharge |
| cmd_valid | output | 1 | A command other than no-op was decoded |
| cmd_code | output | 4 | Decoded command code (R1) |
| bank_open | output | NBANK | One bit per bank, 1 = row open |
| proto_err | output | 1 | The decoded command was illegal |
| self_refresh | output | 1 | Device is in self-refresh |
| power_down | output | 1 | Device is in power-down |

## Verification
Every result of a command taken at a rising edge is registered by that edge. So `cmd_valid`, `cmd_code`, `proto_err`, `bank_open` and the power flags are due one full cycle later, and the bench reads them at the falling edge that follows. A change on `cke` shows up one edge later still, as whether the next command is decoded. The bench drives every input on a falling edge, advances its model of that edge, and compares all outputs at the next falling edge. Directed runs place commands exactly TRCD, TRAS and TMRD edges away, and one edge too early. They also insert disabled edges, so the timing windows are met exactly and missed by one.

// File: rtl/sdrmon_pkg.sv
package sdrmon_pkg;

   typedef enum logic [3:0] {
      CMD_NOP  = 4'd0,
      CMD_ACT  = 4'd1,
      CMD_RD   = 4'd2,
      CMD_WR   = 4'd3,
      CMD_PRE  = 4'd4,
      CMD_PREA = 4'd5,
      CMD_REF  = 4'd6,
      CMD_MRS  = 4'd7,
      CMD_BST  = 4'd8
   } sdr_cmd_e;

endpackage

// File: rtl/sdrmon_decode.sv
module sdrmon_decode
   import sdrmon_pkg::*;
(
   input  logic     cs_n,
   input  logic     ras_n,
   input  logic     cas_n,
   input  logic     we_n,
   input  logic     all_banks,
   output sdr_cmd_e cmd_o
);

   always_comb begin
      cmd_o = CMD_NOP;
      if (!cs_n) begin
         unique case ({ras_n, cas_n, we_n})
            3'b011:  cmd_o = CMD_ACT;
            3'b101:  cmd_o = CMD_RD;
            3'b100:  cmd_o = CMD_WR;
            3'b010:  cmd_o = all_banks ? CMD_PREA : CMD_PRE;
            3'b001:  cmd_o = CMD_REF;
            3'b000:  cmd_o = CMD_MRS;
            3'b110:  cmd_o = CMD_BST;
            default: cmd_o = CMD_NOP;
         endcase
      end
   end

endmodule

// File: rtl/sdrmon_delay.sv
module sdrmon_delay #(
   parameter int DLY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic load_i,
   output logic done_o
);

   if (DLY < 1) begin : g_bad_dly
      $error("sdrmon_delay: DLY must be at least 1");
   end

   if (DLY > 1) begin : g_cnt
      localparam int W = $clog2(DLY);
      logic [W-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt <= '0;
         else if (load_i)
            cnt <= W'(DLY - 1);
         else if (en_i && cnt != '0)
            cnt <= cnt - 1'b1;
      end

      assign done_o = (cnt == '0);

      // counters hold while the clock is gated
      assert_cnt_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (!en_i && !load_i) |=> $stable(cnt));
   end else begin : g_none
      logic unused_dly;
      assign unused_dly = ^{clk, rst_n, en_i, load_i};
      assign done_o = 1'b1;
   end

endmodule

// File: rtl/sdrmon_bank.sv
module sdrmon_bank #(
   parameter int TRCD = 3,
   parameter int TRAS = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic act_i,
   input  logic close_i,
   output logic open_o,
   output logic rw_ok_o,
   output logic pre_ok_o
);

   logic rcd_done;
   logic ras_done;

   sdrmon_delay #(.DLY(TRCD)) u_rcd (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .load_i(act_i), .done_o(rcd_done)
   );

   sdrmon_delay #(.DLY(TRAS)) u_ras (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .load_i(act_i), .done_o(ras_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         open_o <= 1'b0;
      else if (act_i)
         open_o <= 1'b1;
      else if (close_i)
         open_o <= 1'b0;
   end

   assign rw_ok_o  = open_o && rcd_done;
   assign pre_ok_o = !open_o || ras_done;

   assert_open_from_act_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_o) |-> $past(act_i));

   assert_close_after_tras_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(open_o) |-> $past(pre_ok_o));

   assert_act_only_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      act_i |-> !open_o);

endmodule

// File: rtl/sdrmon_power.sv
module sdrmon_power (
   input  logic clk,
   input  logic rst_n,
   input  logic cke,
   input  logic ref_ok_i,
   output logic active_o,
   output logic self_ref_o,
   output logic pdown_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_o   <= 1'b0;
         self_ref_o <= 1'b0;
         pdown_o    <= 1'b0;
      end else begin
         active_o <= cke;
         if (cke) begin
            self_ref_o <= 1'b0;
            pdown_o    <= 1'b0;
         end else if (active_o) begin
            if (ref_ok_i)
               self_ref_o <= 1'b1;
            else
               pdown_o <= 1'b1;
         end
      end
   end

   assert_lowpower_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(self_ref_o && pdown_o));

   assert_sr_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      self_ref_o |-> !active_o);

endmodule

// File: rtl/sdr_cmd_monitor.sv
module sdr_cmd_monitor
   import sdrmon_pkg::*;
#(
   parameter int NBANK = 4,
   parameter int TRCD  = 3,
   parameter int TRAS  = 6,
   parameter int TMRD  = 2,
   localparam int BA_W = $clog2(NBANK)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cke,
   input  logic            cs_n,
   input  logic            ras_n,
   input  logic            cas_n,
   input  logic            we_n,
   input  logic [BA_W-1:0] ba,
   input  logic            addr_ap,
   output logic            cmd_valid,
   output logic [3:0]      cmd_code,
   output logic [NBANK-1:0] bank_open,
   output logic            proto_err,
   output logic            self_refresh,
   output logic            power_down
);

   if (!(NBANK == 2 || NBANK == 4 || NBANK == 8)) begin : g_bad_nbank
      $error("sdr_cmd_monitor: NBANK must be 2, 4 or 8");
   end
   if (TRCD < 1 || TRAS < 1 || TMRD < 1) begin : g_bad_timing
      $error("sdr_cmd_monitor: timing parameters must be at least 1");
   end

   sdr_cmd_e         cmd;
   sdr_cmd_e         code_q;
   logic             active;
   logic             legal;
   logic             mrs_done;
   logic [NBANK-1:0] sel;
   logic [NBANK-1:0] rw_ok;
   logic [NBANK-1:0] pre_ok;
   logic [NBANK-1:0] act_v;
   logic [NBANK-1:0] close_v;
   logic             take;

   sdrmon_decode u_dec (
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .all_banks(addr_ap), .cmd_o(cmd)
   );

   sdrmon_power u_pwr (
      .clk(clk), .rst_n(rst_n), .cke(cke),
      .ref_ok_i(take && cmd == CMD_REF),
      .active_o(active), .self_ref_o(self_refresh), .pdown_o(power_down)
   );

   sdrmon_delay #(.DLY(TMRD)) u_mrd (
      .clk(clk), .rst_n(rst_n), .en_i(active),
      .load_i(take && cmd == CMD_MRS), .done_o(mrs_done)
   );

   assign sel = NBANK'(1) << ba;

   always_comb begin
      legal = mrs_done;
      unique case (cmd)
         CMD_ACT:         legal = mrs_done && !bank_open[ba];
         CMD_RD, CMD_WR:  legal = mrs_done && rw_ok[ba];
         CMD_PRE:         legal = mrs_done && pre_ok[ba];
         CMD_PREA:        legal = mrs_done && (&pre_ok);
         CMD_REF,
         CMD_MRS:         legal = mrs_done && (bank_open == '0);
         default:         legal = mrs_done;
      endcase
   end

   assign take = active && cmd != CMD_NOP && legal;

   for (genvar i = 0; i < NBANK; i++) begin : g_bank
      assign act_v[i]   = take && cmd == CMD_ACT && sel[i];
      assign close_v[i] = take && ((cmd == CMD_PRE && sel[i]) || cmd == CMD_PREA);

      sdrmon_bank #(.TRCD(TRCD), .TRAS(TRAS)) u_bank (
         .clk(clk), .rst_n(rst_n), .en_i(active),
         .act_i(act_v[i]), .close_i(close_v[i]),
         .open_o(bank_open[i]), .rw_ok_o(rw_ok[i]), .pre_ok_o(pre_ok[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         code_q    <= CMD_NOP;
         proto_err <= 1'b0;
      end else begin
         cmd_valid <= active && cmd != CMD_NOP;
         code_q    <= active ? cmd : CMD_NOP;
         proto_err <= active && cmd != CMD_NOP && !legal;
      end
   end

   assign cmd_code = code_q;

   assert_err_has_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> cmd_valid);

   assert_gated_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !cmd_valid);

   assert_rw_needs_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !proto_err && (code_q == CMD_RD || code_q == CMD_WR))
         |-> bank_open[$past(ba)]);

   assert_mrs_all_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !proto_err && code_q == CMD_MRS) |-> (bank_open == '0));

endmodule

// File: tb/tb_sdr_cmd_monitor.sv
module tb_sdr_cmd_monitor;

   localparam int NB   = 4;
   localparam int TRCD = 3;
   localparam int TRAS = 6;
   localparam int TMRD = 2;

   localparam bit [2:0] P_ACT = 3'b011, P_RD  = 3'b101, P_WR  = 3'b100,
                        P_PRE = 3'b010, P_REF = 3'b001, P_MRS = 3'b000,
                        P_BST = 3'b110, P_NOP = 3'b111;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cke = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0] ba = '0;
   logic addr_ap = 1'b0;
   logic cmd_valid, proto_err, self_refresh, power_down;
   logic [3:0] cmd_code;
   logic [NB-1:0] bank_open;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // reference model state
   bit ck_m = 0, sr_m = 0, pd_m = 0;
   bit open_m [NB];
   int rcd_m [NB];
   int ras_m [NB];
   int mrs_m = 0;
   int e_valid, e_code, e_err;

   always #4 clk = ~clk;

   sdr_cmd_monitor #(.NBANK(NB), .TRCD(TRCD), .TRAS(TRAS), .TMRD(TMRD)) dut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr_ap(addr_ap),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .bank_open(bank_open),
      .proto_err(proto_err), .self_refresh(self_refresh), .power_down(power_down)
   );

   function automatic int dec(bit [2:0] p, bit ap);
      case (p)
         P_ACT: return 1;
         P_RD:  return 2;
         P_WR:  return 3;
         P_PRE: return ap ? 5 : 4;
         P_REF: return 6;
         P_MRS: return 7;
         P_BST: return 8;
         default: return 0;
      endcase
   endfunction

   function automatic string err_tag(int code);
      case (code)
         1: return "R3";
         2, 3: return "R4";
         4: return "R5";
         5: return "R6";
         6: return "R8";
         7: return "R7";
         default: return "R1";
      endcase
   endfunction

   function automatic int open_vec();
      int v = 0;
      for (int i = 0; i < NB; i++) if (open_m[i]) v |= (1 << i);
      return v;
   endfunction

   task automatic chk(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s got=%0d expected=%0d at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic model_edge(input bit c_cke, input bit csn, input bit [2:0] p,
                             input int b, input bit ap);
      int code;
      bit legal, anyo, anyy;
      code = csn ? 0 : dec(p, ap);
      e_valid = 0; e_code = 0; e_err = 0;
      if (ck_m) begin
         anyo = 0; anyy = 0;
         for (int i = 0; i < NB; i++) begin
            anyo |= open_m[i];
            anyy |= open_m[i] && ras_m[i] != 0;
         end
         legal = (mrs_m == 0);
         case (code)
            1: legal &= !open_m[b];
            2, 3: legal &= open_m[b] && rcd_m[b] == 0;
            4: legal &= !(open_m[b] && ras_m[b] != 0);
            5: legal &= !anyy;
            6, 7: legal &= !anyo;
            default: ;
         endcase
         if (code != 0) begin
            e_valid = 1; e_code = code; e_err = !legal;
         end
         for (int i = 0; i < NB; i++) begin
            if (rcd_m[i] > 0) rcd_m[i]--;
            if (ras_m[i] > 0) ras_m[i]--;
         end
         if (mrs_m > 0) mrs_m--;
         if (code != 0 && legal) begin
            case (code)
               1: begin open_m[b] = 1; rcd_m[b] = TRCD - 1; ras_m[b] = TRAS - 1; end
               4: open_m[b] = 0;
               5: for (int i = 0; i < NB; i++) open_m[i] = 0;
               7: mrs_m = TMRD - 1;
               default: ;
            endcase
         end
         if (!c_cke) begin
            if (code == 6 && legal) sr_m = 1; else pd_m = 1;
         end
      end
      if (c_cke) begin sr_m = 0; pd_m = 0; end
      ck_m = c_cke;
   endtask

   task automatic step(input bit c_cke, input bit [2:0] p, input int b,
                       input bit ap = 0, input bit csn = 0);
      cke = c_cke; cs_n = csn; {ras_n, cas_n, we_n} = p; ba = b[1:0]; addr_ap = ap;
      model_edge(c_cke, csn, p, b, ap);
      @(negedge clk);
      chk("R1 cmd_valid", int'(cmd_valid), e_valid);
      chk("R1 cmd_code", int'(cmd_code), e_code);
      chk({err_tag(e_code), " proto_err"}, int'(proto_err), e_err);
      chk("R11 bank_open", int'(bank_open), open_vec());
      chk("R9 self_refresh", int'(self_refresh), int'(sr_m));
      chk("R9 power_down", int'(power_down), int'(pd_m));
   endtask

   initial begin
      #(8 * 190000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int r, b;
      bit c, ap, csn;
      bit [2:0] p;
      void'($urandom(32'h1d5e_0c4a));
      for (int i = 0; i < NB; i++) begin open_m[i] = 0; rcd_m[i] = 0; ras_m[i] = 0; end
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 reset cmd_valid", int'(cmd_valid), 0);
      chk("R11 reset proto_err", int'(proto_err), 0);
      chk("R11 reset bank_open", int'(bank_open), 0);
      chk("R11 reset low power", int'(self_refresh | power_down), 0);
      rst_n = 1'b1;

      // R2: first edge after reset is not enabled
      step(1, P_ACT, 0);
      chk("R2 gated activate", int'(cmd_valid), 0);
      chk("R2 gated activate state", int'(bank_open), 0);
      step(1, P_ACT, 1);                         // opens bank 1
      chk("R3 activate opens", int'(bank_open[1]), 1);
      step(1, P_RD, 1);
      chk("R4 read before TRCD", int'(proto_err), 1);
      step(1, P_NOP, 0);
      step(1, P_RD, 1);
      chk("R4 read at TRCD", int'(proto_err), 0);
      step(1, P_ACT, 1);
      chk("R3 activate on open bank", int'(proto_err), 1);
      step(1, P_PRE, 1);
      chk("R5 precharge before TRAS", int'(proto_err), 1);
      chk("R11 bank stays open", int'(bank_open[1]), 1);
      step(1, P_ACT, 2);
      step(1, P_PRE, 0, 1);
      chk("R6 precharge-all blocked", int'(proto_err), 1);
      chk("R6 none closed", int'(bank_open), 6);
      step(1, P_PRE, 1);
      chk("R5 precharge closes", int'(bank_open), 4);
      step(1, P_REF, 0);
      chk("R8 refresh with open bank", int'(proto_err), 1);
      step(1, P_MRS, 0);
      chk("R7 mode load with open bank", int'(proto_err), 1);
      step(1, P_NOP, 0);
      step(1, P_PRE, 0, 1);
      chk("R6 precharge-all closes", int'(bank_open), 0);
      step(1, P_MRS, 0);
      chk("R7 legal mode load", int'(proto_err), 0);
      step(1, P_ACT, 0);
      chk("R7 command inside settle window", int'(proto_err), 1);
      step(1, P_ACT, 0);
      chk("R7 command after settle", int'(proto_err), 0);
      step(0, P_NOP, 0);
      chk("R9 power-down entry", int'(power_down), 1);
      step(0, P_NOP, 0);
      step(1, P_RD, 0);
      chk("R2 disabled edge not decoded", int'(cmd_valid), 0);
      chk("R9 power-down exit", int'(power_down), 0);
      step(1, P_RD, 0);
      chk("R10 TRCD frozen while gated", int'(proto_err), 1);
      step(1, P_NOP, 0);
      step(1, P_WR, 0);
      chk("R4 write at TRCD", int'(proto_err), 0);
      step(1, P_NOP, 0);
      step(1, P_PRE, 0, 1);
      chk("R6 precharge-all at TRAS", int'(bank_open), 0);
      step(0, P_REF, 0);
      chk("R9 self-refresh entry", int'(self_refresh), 1);
      chk("R1 refresh code", int'(cmd_code), 6);
      step(0, P_NOP, 0);
      chk("R9 self-refresh held", int'(self_refresh), 1);
      step(1, P_ACT, 3);
      chk("R9 self-refresh exit", int'(self_refresh), 0);
      chk("R2 exit edge not decoded", int'(bank_open[3]), 0);
      step(1, P_BST, 0);
      chk("R1 burst stop", int'(cmd_code), 8);

      // constrained random phase
      for (int n = 0; n < 3000; n++) begin
         r = $urandom % 16;
         b = $urandom % NB;
         ap = ($urandom % 2) == 1;
         c = ($urandom % 12) != 0;
         csn = (r == 15);
         case (r)
            0, 1, 2, 3: p = P_ACT;
            4, 5: p = P_RD;
            6, 7: p = P_WR;
            8, 9: begin p = P_PRE; ap = 0; end
            10: begin p = P_PRE; ap = 1; end
            11: p = P_REF;
            12: p = (($urandom % 3) == 0) ? P_MRS : P_NOP;
            13: p = P_BST;
            default: p = P_NOP;
         endcase
         step(c, p, b, ap, csn);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule